// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit resolves the operand address of an instruction for a small 8-bit processor with a 16-bit address space. The sequencer hands it one request: an addressing-mode code, the two index registers, the program counter (pointing at the first operand byte) and, for branches, whether the branch is taken. The unit then fetches operand bytes and indirect pointer bytes through a byte-wide read port. It returns the effective address, the program counter advanced past the operand bytes, and the number of extra cycles the access costs. It does not execute the instruction.

The unit keeps the address-wrap rules the processor is known for. Zero-page results and zero-page pointers never leave page zero. An indirect jump whose pointer sits at the last byte of a page takes its high byte from the first byte of that same page. Penalty cycles for crossing a page apply only to the read-type indexed modes. Store and read-modify-write users pick the fixed-cycle variants, which give the same address with no penalty.

All three data paths use valid/ready. A request is accepted only while `req_ready` is high, and one request is handled at a time. A result stays on the result port, unchanged, until `res_ready` is seen high. A memory read stays on the read port, unchanged, until `mem_req_ready` is high. Only one read is outstanding at a time. Its byte comes back with `mem_rsp_valid` in any later cycle, and the response side has no back-pressure.

Top module: `ea_gen`

## Requirements
- R1: After a request is accepted, `req_ready` stays low until the result handshake completes. While `res_valid` is high and `res_ready` is low, the address, program counter and penalty outputs hold steady.
- R2: A memory read request holds its address until it is accepted. No new read is issued while an earlier read has not yet returned its byte.
- R3: Mode codes are 0 immediate, 1 zero page, 2 zero page+X, 3 zero page+Y, 4 absolute, 5 absolute+X, 6 absolute+Y, 7 pre-indexed indirect (X), 8 post-indexed indirect (Y), 9 relative, 10 indirect jump, 11 absolute+X fixed, 12 absolute+Y fixed, 13 post-indexed indirect fixed, 14 and 15 implied. Two-byte operands are read low byte first at the program counter. The returned program counter equals the input advanced by the number of operand bytes.
- R4: Immediate mode issues no memory read. It returns the input program counter as the address and that value plus one as the new program counter.
- R5: Zero-page modes return {0x00, operand + index} with the sum kept to 8 bits. The plain zero-page mode adds nothing.
- R6: The absolute modes return {high, low} plus the zero-extended index. Absolute+X and absolute+Y report penalty 1 exactly when the index carries out of the low address byte, and 0 otherwise.
- R7: The three fixed-cycle modes (11, 12, 13) return the same address as their read-type counterparts with penalty 0.
- R8: Pre-indexed indirect reads the pointer low byte at {0x00, operand+X} and the high byte at {0x00, operand+X+1}, both sums kept to 8 bits. The pointer is the address and the penalty is 0.
- R9: Post-indexed indirect reads the pointer at {0x00, operand} and {0x00, operand+1 mod 256}, then adds Y. Penalty is 1 when adding Y carries out of the low byte.
- R10: The indirect jump reads a two-byte pointer address P. The target low byte comes from P, and the high byte comes from {P[15:8], P[7:0]+1 mod 256}. So a pointer at xxFF takes its high byte from xx00. The penalty is 0.
- R11: Relative mode returns the next-instruction address (input PC+1) plus the sign-extended operand. The penalty is 0 when the branch is not taken, 1 when taken within the same page as the next instruction, and 2 when taken into another page.
- R12: Implied modes issue no memory read. They return address 0x0000, the unchanged program counter and penalty 0.
- R13: Out of reset the unit has `req_ready` high, `res_valid` low and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this cycle if valid |
| req_mode | input | 4 | Addressing-mode code (see R3) |
| req_x | input | 8 | X index register |
| req_y | input | 8 | Y index register |
| req_pc | input | 16 | Program counter at first operand byte |
| req_taken | input | 1 | Branch condition holds (relative mode) |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 16 | Read address |
| mem_rsp_valid | input | 1 | Read byte returned |
| mem_rsp_data | input | 8 | Returned byte |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 16 | Effective address |
| res_pc | output | 16 | Program counter after operand bytes |
| res_pen | output | 2 | Extra cycle count |

## Verification
The hardest cases to reach are the wrap corners. These are a pre-indexed pointer whose high byte wraps from 0xFF to 0x00, a post-indexed pointer at 0xFF whose added Y then also crosses a page, and an indirect jump through a pointer at a page's last byte. The bench reaches each one by placing the operand and pointer bytes in its memory model at exactly those addresses. It also puts distinct decoy bytes at the addresses a wrong carry would read, so any wrap error changes the result. The memory model's accept signal is driven by a pseudo-random stall pattern during the multi-read modes, and one result is held under back-pressure for several cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    M_IMM     = 4'd0,
    M_ZPG     = 4'd1,
    M_ZPX     = 4'd2,
    M_ZPY     = 4'd3,
    M_ABS     = 4'd4,
    M_ABX     = 4'd5,
    M_ABY     = 4'd6,
    M_INDX    = 4'd7,
    M_INDY    = 4'd8,
    M_REL     = 4'd9,
    M_JIND    = 4'd10,
    M_ABX_FX  = 4'd11,
    M_ABY_FX  = 4'd12,
    M_INDY_FX = 4'd13,
    M_IMPL    = 4'd14
  } ea_mode_e;

  typedef enum logic [1:0] {
    IX_NONE = 2'd0,
    IX_X    = 2'd1,
    IX_Y    = 2'd2
  } ix_sel_e;

  // per-mode attributes driving sequencing and arithmetic
  typedef struct packed {
    logic [1:0] opr_n;   // operand bytes to fetch at PC
    logic       use_ptr; // two further pointer-byte reads
    logic       ptr_abs; // pointer page comes from operand high byte
    ix_sel_e    ix;      // index source
    logic       pre_ix;  // index applied to pointer location
    logic       zp_res;  // result confined to page zero
    logic       pen_en;  // page-cross penalty enabled
    logic       is_rel;  // branch target computation
    logic       is_imm;  // address is the PC itself
  } ea_attr_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPR0 = 3'd1,
    S_OPR1 = 3'd2,
    S_PTR0 = 3'd3,
    S_PTR1 = 3'd4,
    S_OUT  = 3'd5
  } ea_state_e;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] mode,
  output ea_attr_t   attr
);

  always_comb begin
    attr = '0;
    attr.ix = IX_NONE;
    case (mode)
      M_IMM: attr.is_imm = 1'b1;
      M_ZPG: begin
        attr.opr_n  = 2'd1;
        attr.zp_res = 1'b1;
      end
      M_ZPX: begin
        attr.opr_n  = 2'd1;
        attr.zp_res = 1'b1;
        attr.ix     = IX_X;
      end
      M_ZPY: begin
        attr.opr_n  = 2'd1;
        attr.zp_res = 1'b1;
        attr.ix     = IX_Y;
      end
      M_ABS: attr.opr_n = 2'd2;
      M_ABX: begin
        attr.opr_n  = 2'd2;
        attr.ix     = IX_X;
        attr.pen_en = 1'b1;
      end
      M_ABY: begin
        attr.opr_n  = 2'd2;
        attr.ix     = IX_Y;
        attr.pen_en = 1'b1;
      end
      M_ABX_FX: begin
        attr.opr_n = 2'd2;
        attr.ix    = IX_X;
      end
      M_ABY_FX: begin
        attr.opr_n = 2'd2;
        attr.ix    = IX_Y;
      end
      M_INDX: begin
        attr.opr_n   = 2'd1;
        attr.use_ptr = 1'b1;
        attr.pre_ix  = 1'b1;
        attr.ix      = IX_X;
      end
      M_INDY: begin
        attr.opr_n   = 2'd1;
        attr.use_ptr = 1'b1;
        attr.ix      = IX_Y;
        attr.pen_en  = 1'b1;
      end
      M_INDY_FX: begin
        attr.opr_n   = 2'd1;
        attr.use_ptr = 1'b1;
        attr.ix      = IX_Y;
      end
      M_REL: begin
        attr.opr_n  = 2'd1;
        attr.is_rel = 1'b1;
      end
      M_JIND: begin
        attr.opr_n   = 2'd2;
        attr.use_ptr = 1'b1;
        attr.ptr_abs = 1'b1;
      end
      default: attr = '0; // implied / accumulator
    endcase
  end

endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW    = 16,
  parameter int PEN_W = 2
) (
  input  ix_sel_e           ix,
  input  logic              use_ptr,
  input  logic              pre_ix,
  input  logic              zp_res,
  input  logic              pen_en,
  input  logic              is_rel,
  input  logic              is_imm,
  input  logic              taken,
  input  logic [AW/2-1:0]   op_lo,
  input  logic [AW/2-1:0]   op_hi,
  input  logic [AW/2-1:0]   ptr_lo,
  input  logic [AW/2-1:0]   ptr_hi,
  input  logic [AW/2-1:0]   x,
  input  logic [AW/2-1:0]   y,
  input  logic [AW-1:0]     pc_start,
  input  logic [AW-1:0]     pc_next,
  output logic [AW-1:0]     addr,
  output logic [PEN_W-1:0]  pen
);

  localparam int BW = AW / 2;

  logic [BW-1:0] iv;
  logic [AW-1:0] base;
  logic [BW:0]   lo_sum;
  logic [AW-1:0] rel_tgt;

  always_comb begin
    case (ix)
      IX_X:    iv = x;
      IX_Y:    iv = y;
      default: iv = '0;
    endcase
    base    = use_ptr ? {ptr_hi, ptr_lo} : {op_hi, op_lo};
    lo_sum  = {1'b0, base[BW-1:0]} + {1'b0, iv};
    rel_tgt = pc_next + {{BW{op_lo[BW-1]}}, op_lo};
    addr    = base + {{BW{1'b0}}, iv};
    pen     = '0;
    if (is_imm) begin
      addr = pc_start;
    end else if (zp_res) begin
      addr = {{BW{1'b0}}, op_lo + iv};
    end else if (pre_ix) begin
      addr = base;
    end else if (is_rel) begin
      addr = rel_tgt;
      if (taken)
        pen = (rel_tgt[AW-1:BW] != pc_next[AW-1:BW]) ? PEN_W'(2) : PEN_W'(1);
    end else if (pen_en && lo_sum[BW]) begin
      pen = PEN_W'(1);
    end
  end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  ea_attr_t         req_attr,
  input  logic [AW/2-1:0]  req_x,
  input  logic [AW/2-1:0]  req_y,
  input  logic [AW-1:0]    req_pc,
  input  logic             req_taken,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW/2-1:0]  mem_rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output ea_attr_t         attr_q,
  output logic [AW/2-1:0]  x_q,
  output logic [AW/2-1:0]  y_q,
  output logic             taken_q,
  output logic [AW-1:0]    pc0_q,
  output logic [AW-1:0]    pc_q,
  output logic [AW/2-1:0]  op_lo_q,
  output logic [AW/2-1:0]  op_hi_q,
  output logic [AW/2-1:0]  ptr_lo_q,
  output logic [AW/2-1:0]  ptr_hi_q
);

  localparam int BW = AW / 2;

  ea_state_e     state;
  logic          pend;
  logic          fetching;
  logic [BW-1:0] ptr_page;
  logic [BW-1:0] ptr_loc;
  ea_state_e     after_opr0;
  ea_state_e     after_opr1;

  assign fetching   = (state == S_OPR0) || (state == S_OPR1) ||
                      (state == S_PTR0) || (state == S_PTR1);
  assign req_ready     = (state == S_IDLE);
  assign res_valid     = (state == S_OUT);
  assign mem_req_valid = fetching && !pend;

  assign ptr_page   = attr_q.ptr_abs ? op_hi_q : '0;
  assign ptr_loc    = op_lo_q + (attr_q.pre_ix ? x_q : '0);
  assign after_opr0 = (attr_q.opr_n == 2'd2) ? S_OPR1 :
                      attr_q.use_ptr ? S_PTR0 : S_OUT;
  assign after_opr1 = attr_q.use_ptr ? S_PTR0 : S_OUT;

  always_comb begin
    case (state)
      S_OPR0, S_OPR1: mem_addr = pc_q;
      S_PTR0:         mem_addr = {ptr_page, ptr_loc};
      S_PTR1:         mem_addr = {ptr_page, ptr_loc + BW'(1)};
      default:        mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pend     <= 1'b0;
      attr_q   <= '0;
      x_q      <= '0;
      y_q      <= '0;
      taken_q  <= 1'b0;
      pc0_q    <= '0;
      pc_q     <= '0;
      op_lo_q  <= '0;
      op_hi_q  <= '0;
      ptr_lo_q <= '0;
      ptr_hi_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            attr_q   <= req_attr;
            x_q      <= req_x;
            y_q      <= req_y;
            taken_q  <= req_taken;
            pc0_q    <= req_pc;
            pc_q     <= req_pc + (req_attr.is_imm ? AW'(1) : AW'(0));
            op_lo_q  <= '0;
            op_hi_q  <= '0;
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
            state    <= (req_attr.opr_n == 2'd0) ? S_OUT : S_OPR0;
          end
        end
        S_OUT: begin
          if (res_ready) state <= S_IDLE;
        end
        default: begin
          if (mem_req_valid && mem_req_ready) pend <= 1'b1;
          if (pend && mem_rsp_valid) begin
            pend <= 1'b0;
            case (state)
              S_OPR0: begin
                op_lo_q <= mem_rsp_data;
                pc_q    <= pc_q + AW'(1);
                state   <= after_opr0;
              end
              S_OPR1: begin
                op_hi_q <= mem_rsp_data;
                pc_q    <= pc_q + AW'(1);
                state   <= after_opr1;
              end
              S_PTR0: begin
                ptr_lo_q <= mem_rsp_data;
                state    <= S_PTR1;
              end
              default: begin
                ptr_hi_q <= mem_rsp_data;
                state    <= S_OUT;
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW    = 16,
  parameter int PEN_W = 2,
  parameter int MW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [MW-1:0]    req_mode,
  input  logic [AW/2-1:0]  req_x,
  input  logic [AW/2-1:0]  req_y,
  input  logic [AW-1:0]    req_pc,
  input  logic             req_taken,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW/2-1:0]  mem_rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [AW-1:0]    res_addr,
  output logic [AW-1:0]    res_pc,
  output logic [PEN_W-1:0] res_pen
);

  localparam int BW = AW / 2;

  ea_attr_t      req_attr;
  ea_attr_t      attr_q;
  logic [BW-1:0] x_q, y_q, op_lo_q, op_hi_q, ptr_lo_q, ptr_hi_q;
  logic [AW-1:0] pc0_q, pc_q;
  logic          taken_q;

  ea_decode u_decode (
    .mode (req_mode[3:0]),
    .attr (req_attr)
  );

  ea_ctrl #(.AW(AW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_attr      (req_attr),
    .req_x         (req_x),
    .req_y         (req_y),
    .req_pc        (req_pc),
    .req_taken     (req_taken),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .attr_q        (attr_q),
    .x_q           (x_q),
    .y_q           (y_q),
    .taken_q       (taken_q),
    .pc0_q         (pc0_q),
    .pc_q          (pc_q),
    .op_lo_q       (op_lo_q),
    .op_hi_q       (op_hi_q),
    .ptr_lo_q      (ptr_lo_q),
    .ptr_hi_q      (ptr_hi_q)
  );

  ea_calc #(.AW(AW), .PEN_W(PEN_W)) u_calc (
    .ix       (attr_q.ix),
    .use_ptr  (attr_q.use_ptr),
    .pre_ix   (attr_q.pre_ix),
    .zp_res   (attr_q.zp_res),
    .pen_en   (attr_q.pen_en),
    .is_rel   (attr_q.is_rel),
    .is_imm   (attr_q.is_imm),
    .taken    (taken_q),
    .op_lo    (op_lo_q),
    .op_hi    (op_hi_q),
    .ptr_lo   (ptr_lo_q),
    .ptr_hi   (ptr_hi_q),
    .x        (x_q),
    .y        (y_q),
    .pc_start (pc0_q),
    .pc_next  (pc_q),
    .addr     (res_addr),
    .pen      (res_pen)
  );

  assign res_pc = pc_q;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW    = 16,
  parameter int PEN_W = 2,
  parameter int MW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [MW-1:0]    req_mode,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rsp_valid,
  input logic             res_valid,
  input logic             res_ready,
  input logic [AW-1:0]    res_addr,
  input logic [AW-1:0]    res_pc,
  input logic [PEN_W-1:0] res_pen
);

  logic [MW-1:0] mode_q;
  logic          outst;
  logic          mode_fixed, mode_zp, mode_nofetch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      outst  <= 1'b0;
    end else begin
      if (req_valid && req_ready) mode_q <= req_mode;
      if (mem_req_valid && mem_req_ready) outst <= 1'b1;
      else if (mem_rsp_valid)             outst <= 1'b0;
    end
  end

  assign mode_fixed   = (mode_q == MW'(11)) || (mode_q == MW'(12)) || (mode_q == MW'(13));
  assign mode_zp      = (mode_q == MW'(1)) || (mode_q == MW'(2)) || (mode_q == MW'(3));
  assign mode_nofetch = (mode_q == MW'(0)) || (mode_q == MW'(14)) || (mode_q == MW'(15));

  AST_RES_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R1
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_pc) && $stable(res_pen))); // R1
  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))); // R2
  AST_MEM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst); // R2
  AST_IMM_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_q == MW'(0)) |-> (res_pc == res_addr + AW'(1))); // R4
  AST_NO_FETCH_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mode_nofetch); // R12
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_zp) |-> (res_addr[AW-1:AW/2] == '0)); // R5
  AST_FIXED_NO_PEN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_fixed) |-> (res_pen == '0)); // R7
  AST_PEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pen <= PEN_W'(2))); // R11

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .PEN_W(PEN_W), .MW(MW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_mode      (req_mode),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_addr      (res_addr),
  .res_pc        (res_pc),
  .res_pen       (res_pen)
);

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_x = '0, req_y = '0;
  logic [15:0] req_pc = '0;
  logic        req_taken = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [15:0] mem_addr;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_addr, res_pc;
  logic [1:0]  res_pen;

  int n_chk = 0;
  int n_fail = 0;
  int fetch_cnt = 0;
  bit bp_on = 1'b0;
  logic [7:0] lfsr;
  logic [7:0] tbmem [logic [15:0]];

  always #10 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_x(req_x), .req_y(req_y), .req_pc(req_pc), .req_taken(req_taken),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_addr(res_addr), .res_pc(res_pc), .res_pen(res_pen)
  );

  function automatic logic [7:0] rd8(input logic [15:0] a);
    if (tbmem.exists(a)) return tbmem[a];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: accepts with optional stalls, answers one cycle later
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      lfsr          <= 8'h5B;
    end else begin
      lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready <= bp_on ? lfsr[0] : 1'b1;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= rd8(mem_addr);
      if (mem_req_valid && mem_req_ready) fetch_cnt <= fetch_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [3:0] m,
                          input logic [7:0] xv, input logic [7:0] yv,
                          input logic [15:0] pcv, input logic tk,
                          input logic [15:0] ea, input logic [15:0] epc,
                          input logic [1:0] epen, input int efetch, input int hold);
    int n0;
    int guard;
    logic [15:0] a0, p0;
    logic [1:0]  q0;
    @(negedge clk);
    n0 = fetch_cnt;
    req_valid = 1'b1; req_mode = m; req_x = xv; req_y = yv;
    req_pc = pcv; req_taken = tk;
    guard = 0;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid && guard < 1000) begin @(negedge clk); guard++; end
    chk(guard < 1000, tag, "result timeout", guard, 0);
    if (hold > 0) begin
      a0 = res_addr; p0 = res_pc; q0 = res_pen;
      repeat (hold) @(negedge clk);
      chk(res_valid && !req_ready, tag, "R1 valid held", int'(res_valid), 1);
      chk(res_addr == a0 && res_pc == p0 && res_pen == q0, tag, "R1 result stable",
          int'(res_addr), int'(a0));
    end
    chk(res_addr == ea,   tag, "address", int'(res_addr), int'(ea));
    chk(res_pc == epc,    tag, "pc",      int'(res_pc),   int'(epc));
    chk(res_pen == epen,  tag, "penalty", int'(res_pen),  int'(epen));
    chk(fetch_cnt - n0 == efetch, tag, "R3 read count", fetch_cnt - n0, efetch);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R13", "req_ready", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R13", "res_valid", int'(res_valid), 0);
    chk(mem_req_valid == 1'b0, "R13", "mem_req_valid", int'(mem_req_valid), 0);
  endtask

  task automatic t_immediate();
    run_case("R4 imm", 4'd0, 8'h11, 8'h22, 16'h1234, 1'b0, 16'h1234, 16'h1235, 2'd0, 0, 0);
  endtask

  task automatic t_zero_page();
    tbmem[16'h0200] = 8'hF0;
    tbmem[16'h0210] = 8'h80;
    tbmem[16'h0220] = 8'h7E;
    run_case("R5 zpx wrap", 4'd2, 8'h20, 8'h00, 16'h0200, 1'b0, 16'h0010, 16'h0201, 2'd0, 1, 0);
    run_case("R5 zpy wrap", 4'd3, 8'h00, 8'h85, 16'h0210, 1'b0, 16'h0005, 16'h0211, 2'd0, 1, 0);
    run_case("R5 zpg",      4'd1, 8'h40, 8'h40, 16'h0220, 1'b0, 16'h007E, 16'h0221, 2'd0, 1, 0);
  endtask

  task automatic t_absolute();
    tbmem[16'h0300] = 8'h34; tbmem[16'h0301] = 8'h12;
    tbmem[16'h0310] = 8'hF0; tbmem[16'h0311] = 8'h12;
    tbmem[16'h0320] = 8'hF8; tbmem[16'h0321] = 8'h12;
    run_case("R3 abs held R1", 4'd4, 8'h00, 8'h00, 16'h0300, 1'b0, 16'h1234, 16'h0302, 2'd0, 2, 3);
    run_case("R6 abx cross",   4'd5, 8'h20, 8'h00, 16'h0310, 1'b0, 16'h1310, 16'h0312, 2'd1, 2, 0);
    run_case("R6 abx same",    4'd5, 8'h05, 8'h00, 16'h0310, 1'b0, 16'h12F5, 16'h0312, 2'd0, 2, 0);
    run_case("R6 aby cross",   4'd6, 8'h00, 8'h10, 16'h0320, 1'b0, 16'h1308, 16'h0322, 2'd1, 2, 0);
    run_case("R7 abx fixed",   4'd11, 8'h20, 8'h00, 16'h0310, 1'b0, 16'h1310, 16'h0312, 2'd0, 2, 0);
    run_case("R7 aby fixed",   4'd12, 8'h00, 8'h10, 16'h0320, 1'b0, 16'h1308, 16'h0322, 2'd0, 2, 0);
  endtask

  task automatic t_pre_indexed();
    bp_on = 1'b1;
    tbmem[16'h0400] = 8'hF8;
    tbmem[16'h0410] = 8'hFE;
    tbmem[16'h0000] = 8'hCD; tbmem[16'h0001] = 8'hAB;
    tbmem[16'h00FF] = 8'h11; tbmem[16'h0100] = 8'h77; // decoy for a missed wrap
    run_case("R8 indx",      4'd7, 8'h08, 8'h00, 16'h0400, 1'b0, 16'hABCD, 16'h0401, 2'd0, 3, 0);
    run_case("R8 indx wrap", 4'd7, 8'h01, 8'h00, 16'h0410, 1'b0, 16'hCD11, 16'h0411, 2'd0, 3, 0);
    bp_on = 1'b0;
  endtask

  task automatic t_post_indexed();
    tbmem[16'h0420] = 8'hFF;
    run_case("R9 indy cross",  4'd8,  8'h00, 8'hF0, 16'h0420, 1'b0, 16'hCE01, 16'h0421, 2'd1, 3, 0);
    run_case("R9 indy same",   4'd8,  8'h00, 8'h0E, 16'h0420, 1'b0, 16'hCD1F, 16'h0421, 2'd0, 3, 0);
    run_case("R7 indy fixed",  4'd13, 8'h00, 8'hF0, 16'h0420, 1'b0, 16'hCE01, 16'h0421, 2'd0, 3, 0);
  endtask

  task automatic t_jump_indirect();
    bp_on = 1'b1;
    tbmem[16'h0500] = 8'hFF; tbmem[16'h0501] = 8'h30;
    tbmem[16'h30FF] = 8'h80; tbmem[16'h3000] = 8'h40; tbmem[16'h3100] = 8'h99;
    tbmem[16'h0510] = 8'h10; tbmem[16'h0511] = 8'h30;
    tbmem[16'h3010] = 8'h22; tbmem[16'h3011] = 8'h33;
    run_case("R10 jind page quirk", 4'd10, 8'h00, 8'h00, 16'h0500, 1'b0, 16'h4080, 16'h0502, 2'd0, 4, 0);
    run_case("R10 jind plain",      4'd10, 8'h00, 8'h00, 16'h0510, 1'b0, 16'h3322, 16'h0512, 2'd0, 4, 0);
    bp_on = 1'b0;
  endtask

  task automatic t_relative();
    tbmem[16'h4000] = 8'h10;
    tbmem[16'h4002] = 8'hF0;
    run_case("R11 rel taken same",  4'd9, 8'h00, 8'h00, 16'h4000, 1'b1, 16'h4011, 16'h4001, 2'd1, 1, 0);
    run_case("R11 rel taken cross", 4'd9, 8'h00, 8'h00, 16'h4002, 1'b1, 16'h3FF3, 16'h4003, 2'd2, 1, 0);
    run_case("R11 rel not taken",   4'd9, 8'h00, 8'h00, 16'h4002, 1'b0, 16'h3FF3, 16'h4003, 2'd0, 1, 0);
  endtask

  task automatic t_implied();
    run_case("R12 implied 14", 4'd14, 8'h12, 8'h34, 16'h5555, 1'b1, 16'h0000, 16'h5555, 2'd0, 0, 0);
    run_case("R12 implied 15", 4'd15, 8'hFF, 8'hFF, 16'hABCD, 1'b0, 16'h0000, 16'hABCD, 2'd0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_immediate();
    t_zero_page();
    t_absolute();
    t_pre_indexed();
    t_post_indexed();
    t_jump_indirect();
    t_relative();
    t_implied();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule